// File: doc/BRIEF.md
# Word-Serial Operand Register with Single-Cycle Bulk Shifter

This block is an operand store for a scalable, word-serial arithmetic unit. It holds one long operand of up to `MAX_BITS` bits as a ring of `WORD_W`-bit cells. In stream mode, cell 0 is presented to the arithmetic unit as the current word. On each clock edge every active cell passes its contents one place toward cell 0, and the word the arithmetic unit returns enters the highest active cell. After as many stream cycles as there are active words, the operand's first word is back at the read position, now replaced by the computed result.

A multiplexer in front of every storage bit also lets the register shift its whole contents by one bit position, toward the MSB or toward the LSB, in a single clock. This cost does not depend on how many words are in use, so the arithmetic unit never spends word cycles on shifting. A parallel load port and a parallel read port are provided for initialisation and readout.

Top module: `wordserial_shift_store`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it is released, the storage (`parOut`), `wordOut` and `shiftedOut` are all zero.
- R2: When `loadEn` is high, the next edge writes `loadData` into the storage, whatever value `mode` has.
- R3: With `mode` = 2'b00 (hold) and `loadEn` low, an edge leaves the storage and `shiftedOut` unchanged.
- R4: `wordOut` always equals storage bits `WORD_W-1:0` (cell 0), with no added latency.
- R5: With `mode` = 2'b01 (stream), `loadEn` low and an effective active count `u`, each edge moves cell i+1 into cell i for i < u-1 and writes `wordIn` into cell u-1. Cells at index u and above are unchanged.
- R6: Streaming `u` cycles while `wordOut` is fed back on `wordIn` returns the storage to its original contents, so word 0 is again at the read position.
- R7: With `mode` = 2'b10 (shift left), one edge moves every bit of the full register one position toward the MSB. Bit 0 becomes 0, and `shiftedOut` becomes the previous MSB, whatever `wordsUsed` is.
- R8: With `mode` = 2'b11 (shift right), one edge moves every bit one position toward the LSB. The MSB takes `fillBit`, and `shiftedOut` becomes the previous bit 0.
- R9: A `wordsUsed` value above the cell count acts as the cell count. A value of 0 makes stream mode leave the storage unchanged.
- R10: `shiftedOut` changes only on shift edges. Load, hold and stream edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Parallel load strobe, highest priority |
| loadData | input | NUM_WORDS*WORD_W (160) | Parallel load value |
| mode | input | 2 | 00 hold, 01 stream, 10 shift left, 11 shift right |
| wordsUsed | input | clog2(NUM_WORDS+1) (3) | Number of active cells for streaming |
| wordIn | input | WORD_W (32) | Result word written into the top active cell |
| fillBit | input | 1 | Bit entering the MSB on a right shift |
| wordOut | output | WORD_W (32) | Current cell 0 contents |
| parOut | output | NUM_WORDS*WORD_W (160) | Whole storage contents |
| shiftedOut | output | 1 | Bit lost by the most recent shift |

## Verification
`parOut` and `shiftedOut` are registered, so a load, shift or stream step is visible one edge after its inputs are applied. `wordOut` follows cell 0 in the same cycle the storage changes. The bench drives inputs on the falling edge. It then waits one full clock and compares all three outputs on the next falling edge against a reference model that it advanced once for that edge. The multi-step alignment check in R6 compares the storage only after exactly `u` such steps.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD   = 2'b00,
    MODE_STREAM = 2'b01,
    MODE_SHL    = 2'b10,
    MODE_SHR    = 2'b11
  } modeT;

  // Strobes from control to datapath; none set means hold.
  typedef struct packed {
    logic load;
    logic stream;
    logic shiftLeft;
    logic shiftRight;
  } strobeT;

endpackage

// File: rtl/wsr_ctrl.sv
module wsr_ctrl
  import wsr_pkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int CNT_W     = 3
) (
  input  logic                 loadEn,
  input  logic [1:0]           mode,
  input  logic [CNT_W-1:0]     wordsUsed,
  output strobeT               strobes,
  output logic [NUM_WORDS-1:0] takeNext,
  output logic [NUM_WORDS-1:0] takeIn
);

  modeT             modeSel;
  logic [CNT_W-1:0] effUsed;

  assign modeSel = modeT'(mode);

  // Load wins over every mode; otherwise decode the mode field.
  always_comb begin
    strobes = '0;
    if (loadEn) begin
      strobes.load = 1'b1;
    end else begin
      case (modeSel)
        MODE_STREAM: strobes.stream     = 1'b1;
        MODE_SHL:    strobes.shiftLeft  = 1'b1;
        MODE_SHR:    strobes.shiftRight = 1'b1;
        default:     ;
      endcase
    end
  end

  // Active word count saturates at the number of physical cells.
  assign effUsed = (wordsUsed > CNT_W'(NUM_WORDS)) ? CNT_W'(NUM_WORDS) : wordsUsed;

  // Per-cell stream selects: below the tail take the next cell, the tail takes wordIn.
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_cellSel
    assign takeNext[i] = strobes.stream && (CNT_W'(i + 1) < effUsed);
    assign takeIn[i]   = strobes.stream && (CNT_W'(i + 1) == effUsed);
  end

endmodule

// File: rtl/wsr_datapath.sv
module wsr_datapath
  import wsr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 5,
  localparam int TOTAL    = WORD_W * NUM_WORDS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobes,
  input  logic [NUM_WORDS-1:0] takeNext,
  input  logic [NUM_WORDS-1:0] takeIn,
  input  logic [TOTAL-1:0]     loadData,
  input  logic [WORD_W-1:0]    wordIn,
  input  logic                 fillBit,
  output logic [TOTAL-1:0]     parOut,
  output logic [WORD_W-1:0]    wordOut,
  output logic                 shiftedOut
);

  logic [TOTAL-1:0] cells;
  logic [TOTAL-1:0] cellNext;
  logic             shiftedNext;

  // One multiplexer per storage bit.
  for (genvar b = 0; b < TOTAL; b++) begin : g_bit
    localparam int WI  = b / WORD_W;
    localparam int OFF = b % WORD_W;
    logic leftSrc;
    logic rightSrc;
    logic nextSrc;

    if (b == 0) begin : g_lsb
      assign leftSrc = 1'b0;
    end else begin : g_lin
      assign leftSrc = cells[b-1];
    end

    if (b == TOTAL - 1) begin : g_msb
      assign rightSrc = fillBit;
    end else begin : g_rin
      assign rightSrc = cells[b+1];
    end

    if (WI == NUM_WORDS - 1) begin : g_top
      assign nextSrc = cells[b];
    end else begin : g_mid
      assign nextSrc = cells[b+WORD_W];
    end

    assign cellNext[b] = strobes.load       ? loadData[b] :
                         strobes.shiftLeft  ? leftSrc     :
                         strobes.shiftRight ? rightSrc    :
                         takeIn[WI]         ? wordIn[OFF] :
                         takeNext[WI]       ? nextSrc     :
                                              cells[b];
  end

  assign shiftedNext = strobes.shiftLeft  ? cells[TOTAL-1] :
                       strobes.shiftRight ? cells[0]       :
                                            shiftedOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cells      <= '0;
      shiftedOut <= 1'b0;
    end else begin
      cells      <= cellNext;
      shiftedOut <= shiftedNext;
    end
  end

  assign parOut  = cells;
  assign wordOut = cells[WORD_W-1:0];

endmodule

// File: rtl/wordserial_shift_store.sv
module wordserial_shift_store
  import wsr_pkg::*;
#(
  parameter int MAX_BITS   = 160,
  parameter int WORD_W     = 32,
  localparam int NUM_WORDS = (MAX_BITS + WORD_W - 1) / WORD_W,
  localparam int TOTAL     = NUM_WORDS * WORD_W,
  localparam int CNT_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [TOTAL-1:0]  loadData,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  wordsUsed,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              fillBit,
  output logic [WORD_W-1:0] wordOut,
  output logic [TOTAL-1:0]  parOut,
  output logic              shiftedOut
);

  strobeT               strobes;
  logic [NUM_WORDS-1:0] takeNext;
  logic [NUM_WORDS-1:0] takeIn;

  wsr_ctrl #(
    .NUM_WORDS(NUM_WORDS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .loadEn   (loadEn),
    .mode     (mode),
    .wordsUsed(wordsUsed),
    .strobes  (strobes),
    .takeNext (takeNext),
    .takeIn   (takeIn)
  );

  wsr_datapath #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .takeNext  (takeNext),
    .takeIn    (takeIn),
    .loadData  (loadData),
    .wordIn    (wordIn),
    .fillBit   (fillBit),
    .parOut    (parOut),
    .wordOut   (wordOut),
    .shiftedOut(shiftedOut)
  );

endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
  parameter int MAX_BITS   = 160,
  parameter int WORD_W     = 32,
  localparam int NUM_WORDS = (MAX_BITS + WORD_W - 1) / WORD_W,
  localparam int TOTAL     = NUM_WORDS * WORD_W,
  localparam int CNT_W     = $clog2(NUM_WORDS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic [TOTAL-1:0]  loadData,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  wordsUsed,
  input logic [WORD_W-1:0] wordIn,
  input logic              fillBit,
  input logic [WORD_W-1:0] wordOut,
  input logic [TOTAL-1:0]  parOut,
  input logic              shiftedOut
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> parOut == $past(loadData));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && mode == 2'b00) |=> $stable(parOut));

  // R7
  shift_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && mode == 2'b10) |=>
      (parOut == {$past(parOut[TOTAL-2:0]), 1'b0}) && (shiftedOut == $past(parOut[TOTAL-1])));

  // R8
  shift_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && mode == 2'b11) |=>
      (parOut == {$past(fillBit), $past(parOut[TOTAL-1:1])}) && (shiftedOut == $past(parOut[0])));

  // R5
  stream_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && mode == 2'b01 && wordsUsed == CNT_W'(1)) |=> wordOut == $past(wordIn));

  if (NUM_WORDS >= 2) begin : g_multi
    // R5
    stream_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!loadEn && mode == 2'b01 && wordsUsed >= CNT_W'(2)) |=> wordOut == $past(parOut[2*WORD_W-1:WORD_W]));
  end

  // R9
  stream_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && mode == 2'b01 && wordsUsed == '0) |=> $stable(parOut));

  // R10
  shifted_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn || !mode[1]) |=> $stable(shiftedOut));

  // R4
  word_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordOut == parOut[WORD_W-1:0]);

endmodule

bind wordserial_shift_store wsr_checker #(
  .MAX_BITS(MAX_BITS),
  .WORD_W  (WORD_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadEn    (loadEn),
  .loadData  (loadData),
  .mode      (mode),
  .wordsUsed (wordsUsed),
  .wordIn    (wordIn),
  .fillBit   (fillBit),
  .wordOut   (wordOut),
  .parOut    (parOut),
  .shiftedOut(shiftedOut)
);

// File: tb/sim_wordserial_shift_store.sv
`timescale 1ns/1ps
module sim_wordserial_shift_store;

  localparam int MAX_BITS  = 160;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = (MAX_BITS + WORD_W - 1) / WORD_W;
  localparam int TOTAL     = NUM_WORDS * WORD_W;
  localparam int CNT_W     = $clog2(NUM_WORDS + 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              loadEn;
  logic [TOTAL-1:0]  loadData;
  logic [1:0]        mode;
  logic [CNT_W-1:0]  wordsUsed;
  logic [WORD_W-1:0] wordIn;
  logic              fillBit;
  logic [WORD_W-1:0] wordOut;
  logic [TOTAL-1:0]  parOut;
  logic              shiftedOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [TOTAL-1:0] expState;
  logic             expShifted;

  always #5 clk = ~clk;

  wordserial_shift_store #(.MAX_BITS(MAX_BITS), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData), .mode(mode),
    .wordsUsed(wordsUsed), .wordIn(wordIn), .fillBit(fillBit),
    .wordOut(wordOut), .parOut(parOut), .shiftedOut(shiftedOut)
  );

  function automatic logic [TOTAL-1:0] randWide();
    logic [TOTAL-1:0] v = '0;
    repeat ((TOTAL + 31) / 32) v = (v << 32) | TOTAL'($urandom);
    return v;
  endfunction

  task automatic checkVec(string tag, string what, logic [TOTAL-1:0] got, logic [TOTAL-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Reference model of one edge, written from the requirements.
  task automatic advanceModel(logic ld, logic [TOTAL-1:0] ldData, logic [1:0] md,
                              int used, logic [WORD_W-1:0] win, logic fill);
    logic [TOTAL-1:0] cur = expState;
    int u = (used > NUM_WORDS) ? NUM_WORDS : used;
    if (ld) begin
      expState = ldData;
    end else if (md == 2'b10) begin
      expShifted = cur[TOTAL-1];
      expState   = cur << 1;
    end else if (md == 2'b11) begin
      expShifted = cur[0];
      expState   = {fill, cur[TOTAL-1:1]};
    end else if (md == 2'b01) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (i < u - 1)       expState[i*WORD_W +: WORD_W] = cur[(i+1)*WORD_W +: WORD_W];
        else if (i == u - 1) expState[i*WORD_W +: WORD_W] = win;
      end
    end
  endtask

  function automatic string tagFor(logic ld, logic [1:0] md, int used);
    if (ld) return "R2";
    case (md)
      2'b00: return "R3";
      2'b01: return (used == 0 || used > NUM_WORDS) ? "R9" : "R5";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Drive at the falling edge, compare at the next falling edge.
  task automatic step(logic ld, logic [TOTAL-1:0] ldData, logic [1:0] md,
                      int used, logic [WORD_W-1:0] win, logic fill);
    string tag = tagFor(ld, md, used);
    loadEn = ld; loadData = ldData; mode = md;
    wordsUsed = CNT_W'(used); wordIn = win; fillBit = fill;
    advanceModel(ld, ldData, md, used, win, fill);
    @(negedge clk);
    checkVec(tag, "parOut", parOut, expState);
    checkVec("R4", "wordOut", TOTAL'(wordOut), TOTAL'(expState[WORD_W-1:0]));
    checkVec(ld || !md[1] ? "R10" : tag, "shiftedOut", TOTAL'(shiftedOut), TOTAL'(expShifted));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TOTAL-1:0] orig;
    void'($urandom(32'd20240611));
    rstN = 1'b0; loadEn = 1'b0; loadData = '0; mode = 2'b00;
    wordsUsed = '0; wordIn = '0; fillBit = 1'b0;
    expState = '0; expShifted = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVec("R1", "parOut", parOut, '0);
    checkVec("R1", "wordOut", TOTAL'(wordOut), '0);
    checkVec("R1", "shiftedOut", TOTAL'(shiftedOut), '0);
    rstN = 1'b1;
    @(negedge clk);
    checkVec("R1", "parOut after release", parOut, '0);

    // R2: load wins over a shift request
    step(1'b1, randWide(), 2'b10, 5, '0, 1'b1);
    // R3: hold ignores wordIn and fillBit
    step(1'b0, randWide(), 2'b00, 3, 32'hdeadbeef, 1'b1);
    // R7: shift left with a single word in use still moves the whole register
    step(1'b0, '0, 2'b10, 1, '0, 1'b0);
    // R8: shift right with fill one and fill zero
    step(1'b0, '0, 2'b11, 2, '0, 1'b1);
    step(1'b0, '0, 2'b11, 2, '0, 1'b0);

    // R6: feed wordOut back for u cycles and expect the original contents
    for (int u = 1; u <= NUM_WORDS; u++) begin
      step(1'b1, randWide(), 2'b00, 0, '0, 1'b0);
      orig = parOut;
      for (int c = 0; c < u; c++) step(1'b0, '0, 2'b01, u, wordOut, 1'b0);
      checkVec("R6", "parOut after full rotation", parOut, orig);
      step(1'b0, '0, 2'b10, u, '0, 1'b0);
    end

    // R9: counts of zero and above the cell count
    step(1'b1, randWide(), 2'b00, 0, '0, 1'b0);
    step(1'b0, '0, 2'b01, 0, 32'h12345678, 1'b0);
    step(1'b0, '0, 2'b01, (1 << CNT_W) - 1, 32'hcafef00d, 1'b0);
    step(1'b0, '0, 2'b01, NUM_WORDS + 1, 32'h0badc0de, 1'b0);

    // Walking one out through the MSB then back in via fill (R7, R8)
    step(1'b1, {1'b1, {(TOTAL-1){1'b0}}}, 2'b00, 0, '0, 1'b0);
    step(1'b0, '0, 2'b10, 3, '0, 1'b0);
    step(1'b0, '0, 2'b11, 3, '0, 1'b1);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic ld = ($urandom_range(0, 15) == 0);
      step(ld, randWide(), 2'($urandom_range(0, 3)), int'($urandom_range(0, (1 << CNT_W) - 1)),
           WORD_W'($urandom), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule